// File: doc/BRIEF.md
# Preset Counter Timer

This block is the programmable countdown timer of a dual-channel serial controller. Software loads a preset value one byte at a time over the controller's register bus. It arms the count with a read of a command address and disarms it with a read of a second command address. Using reads as commands lets a single bus access act without a data phase.

While the count is armed, the counter drops by one on each prescaler tick. When it reaches zero it raises a ready flag. The controller's interrupt unit takes this flag in as its counter status bit. The counter value can be read back one byte at a time at any moment.

The control is a three-state machine:

- **IDLE** (stopped): ticks are ignored and the count holds.
- **COUNT** (armed): each tick decrements the count.
- **DONE** (expired): the count holds at zero and the ready flag is high.

The transitions are:

- **arm**: any state to COUNT, on a start read; the count is reloaded from the preset.
- **disarm**: any state to IDLE, on a stop read.
- **expire**: COUNT to DONE, on a tick while the count is one or zero.
- **decrement**: COUNT to COUNT, on a tick while the count is above one.

Top module: `preset_timer`

## Requirements
- R1: After reset the ready output is 0, the counter reads 0 and the preset is 0.
- R2: A write to address 6 replaces bits 15:8 of the preset and leaves bits 7:0 unchanged. A write to address 7 replaces bits 7:0 and leaves bits 15:8 unchanged.
- R3: While rd_en is high, address 6 drives counter bits 15:8 onto rdata and address 7 drives counter bits 7:0, in the same cycle and combinationally.
- R4: A read of address 14 returns 0. It loads the counter from the preset, clears ready and enters COUNT, all visible after the next clock edge.
- R5: A read of address 15 returns 0. It clears ready and enters IDLE, and the counter keeps its value.
- R6: In COUNT, each cycle with tick high lowers the counter by one. In IDLE and DONE, tick has no effect on the counter or on ready, and the counter does not change in any state without a tick or a start read.
- R7: For a preset N of 1 or more, ready rises after the Nth tick following the start read. For a preset of 0, ready rises after the first tick.
- R8: After expiry the counter holds 0 and ready stays 1 through further ticks until the next start or stop read.
- R9: A start read while in COUNT reloads the counter from the preset and restarts the countdown.
- R10: Reads of any address other than 6, 7, 14 and 15, and any cycle with rd_en low, return 0 on rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and rd_en |
| tick | input | 1 | Prescaler tick, one cycle wide |
| ready | output | 1 | Counter-ready flag, high in DONE |

## Verification
The bench uses the default parameters: a 16-bit counter built from two 8-bit bytes and a 4-bit address. Presets are held mostly below a few hundred. This lets expiry, the hold at zero, re-arming and the borrow from the upper byte into the lower byte (a preset of 0x0100) occur within short runs. Full 16-bit values such as 0xABCD are still loaded and read back to check the byte lanes.

// File: rtl/preset_timer_pkg.sv
package preset_timer_pkg;
    localparam int PRESET_HI_ADDR = 6;
    localparam int PRESET_LO_ADDR = 7;
    localparam int ARM_ADDR       = 14;
    localparam int DISARM_ADDR    = 15;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/ptm_preset_reg.sv
module ptm_preset_reg
    import preset_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  preset
);
    localparam int NBYTES = CNT_W / BYTE_W;

    // byte 0 is the low byte at PRESET_LO_ADDR; higher bytes at lower addresses
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(PRESET_LO_ADDR - i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                preset[i*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en && addr == BYTE_ADDR) begin
                preset[i*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ptm_fsm.sv
module ptm_fsm
    import preset_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic             tick,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             ready
);
    tmr_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        unique case (st_q)
            ST_IDLE: ;
            ST_DONE: ;
            ST_COUNT: begin
                if (tick) begin
                    if (cnt_q <= CNT_W'(1)) begin
                        cnt_nx = '0;
                        st_nx  = ST_DONE;
                    end else begin
                        cnt_nx = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
        if (disarm) begin
            st_nx  = ST_IDLE;
            cnt_nx = cnt_q;
        end
        if (arm) begin
            st_nx  = ST_COUNT;
            cnt_nx = preset;
        end
    end

    always_comb begin
        count = cnt_q;
        ready = (st_q == ST_DONE);
    end
endmodule

// File: rtl/ptm_rd_mux.sv
module ptm_rd_mux
    import preset_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rdata
);
    localparam int NBYTES = CNT_W / BYTE_W;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (addr == ADDR_W'(PRESET_LO_ADDR - i)) begin
                    rdata = count[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end
endmodule

// File: rtl/preset_timer.sv
module preset_timer
    import preset_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick,
    output logic              ready
);
    logic [CNT_W-1:0] preset_w;
    logic [CNT_W-1:0] count_w;
    logic             arm_w;
    logic             disarm_w;

    assign arm_w    = rd_en && (addr == ADDR_W'(ARM_ADDR));
    assign disarm_w = rd_en && (addr == ADDR_W'(DISARM_ADDR));

    ptm_preset_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_preset (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .preset (preset_w)
    );

    ptm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_w),
        .disarm (disarm_w),
        .tick   (tick),
        .preset (preset_w),
        .count  (count_w),
        .ready  (ready)
    );

    ptm_rd_mux #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rdmux (
        .rd_en (rd_en),
        .addr  (addr),
        .count (count_w),
        .rdata (rdata)
    );
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker
    import preset_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              tick,
    input logic              ready,
    input logic [CNT_W-1:0]  preset_w,
    input logic [CNT_W-1:0]  count_w
);
    logic arm_c, disarm_c, wr_hi_c;
    assign arm_c    = rd_en && addr == ADDR_W'(ARM_ADDR);
    assign disarm_c = rd_en && addr == ADDR_W'(DISARM_ADDR);
    assign wr_hi_c  = wr_en && addr == ADDR_W'(PRESET_HI_ADDR);

    // R4
    arm_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_c |=> (!ready && count_w == $past(preset_w)));

    // R5
    disarm_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_c |=> (!ready && count_w == $past(count_w)));

    // R7
    ready_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(tick) && count_w == '0));

    // R6
    count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm_c) |=> $stable(count_w));

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !arm_c && !disarm_c) |=> (ready && count_w == '0));

    // R2
    hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_c |=> preset_w[BYTE_W-1:0] == $past(preset_w[BYTE_W-1:0]));
endmodule

bind preset_timer ptm_checker #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .tick     (tick),
    .ready    (ready),
    .preset_w (preset_w),
    .count_w  (count_w)
);

// File: tb/preset_timer_tb.sv
module preset_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b0;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // bench model
    logic [15:0] m_preset = '0;
    logic [15:0] m_cnt = '0;
    bit          m_run = 0;
    bit          m_rdy = 0;

    always #5 clk = ~clk;

    preset_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step_cnt(input logic [15:0] c);
        return (c <= 16'd1) ? 16'd0 : c - 16'd1;
    endfunction

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (a == 4'd6) m_preset[15:8] = d;
        if (a == 4'd7) m_preset[7:0] = d;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        if (a == 4'd14) begin m_cnt = m_preset; m_run = 1; m_rdy = 0; end
        if (a == 4'd15) begin m_run = 0; m_rdy = 0; end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); @(negedge clk);
            tick = 1'b0;
            if (m_run) begin
                if (m_cnt <= 16'd1) begin m_run = 0; m_rdy = 1; end
                m_cnt = step_cnt(m_cnt);
            end
        end
    endtask

    task automatic arm(input string req);
        logic [7:0] d;
        do_rd(4'd14, d);
        chk(req, d, 0);
    endtask

    task automatic disarm(input string req);
        logic [7:0] d;
        do_rd(4'd15, d);
        chk(req, d, 0);
    endtask

    task automatic check_state(input string req);
        logic [7:0] hi, lo;
        do_rd(4'd6, hi);
        do_rd(4'd7, lo);
        chk(req, {hi, lo}, m_cnt);
        chk(req, ready, m_rdy);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", ready, 0);
        check_state("R1 count");

        // R10 other addresses and idle bus
        do_rd(4'd3, d);  chk("R10 addr3", d, 0);
        do_rd(4'd12, d); chk("R10 addr12", d, 0);
        #1 chk("R10 rd_en low", rdata, 0);

        // R2 / R3 / R4 byte lanes
        do_wr(4'd6, 8'hAB); do_wr(4'd7, 8'hCD);
        arm("R4 start returns 0");
        check_state("R3 R4 readback ABCD");
        do_wr(4'd6, 8'h12);
        arm("R4 start returns 0");
        check_state("R2 upper only");
        do_wr(4'd7, 8'h34);
        arm("R4 start returns 0");
        check_state("R2 lower only");

        // R5 / R6 stop holds, ticks ignored
        do_ticks(3);
        check_state("R6 decrement");
        disarm("R5 stop returns 0");
        do_ticks(5);
        check_state("R5 R6 stopped hold");

        // R7 preset zero
        do_wr(4'd6, 8'h00); do_wr(4'd7, 8'h00);
        arm("R4");
        chk("R7 zero not ready yet", ready, 0);
        do_ticks(1);
        chk("R7 zero preset first tick", ready, 1);

        // R7 / R8 preset three
        do_wr(4'd7, 8'h03);
        arm("R4");
        chk("R4 start clears ready", ready, 0);
        do_ticks(2);
        chk("R7 before Nth tick", ready, 0);
        do_ticks(1);
        chk("R7 on Nth tick", ready, 1);
        do_ticks(4);
        check_state("R8 hold at zero");
        disarm("R5");
        chk("R5 stop clears ready", ready, 0);

        // R9 restart while counting
        do_wr(4'd7, 8'h05);
        arm("R4");
        do_ticks(3);
        arm("R9");
        check_state("R9 reload");
        do_ticks(5);
        chk("R9 full period after reload", ready, 1);

        // R6 / R7 borrow across bytes
        do_wr(4'd6, 8'h01); do_wr(4'd7, 8'h00);
        arm("R4");
        do_ticks(255);
        check_state("R6 borrow");
        do_ticks(1);
        check_state("R7 expire 0x0100");

        // random mix against model
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: do_wr(4'd6, 8'($urandom_range(0, 1)));
                1: do_wr(4'd7, 8'($urandom));
                2: arm("R4 random");
                3: disarm("R5 random");
                4: do_ticks($urandom_range(1, 40));
                default: check_state("R6 R7 R8 random");
            endcase
        end
        check_state("R6 final");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule